// File: doc/BRIEF.md
# Retimer Bring-Up Sequencer

This block configures an external HDMI retimer over I2C once the link line rate is known. It is given a start strobe. It then finds out which of two silicon variants is on the board by sending a one-byte read to each of two 7-bit addresses in turn, lower address first. It chooses an operating mode from the transmit line rate, using the threshold set that belongs to the variant it found. Finally it walks a table of single-register writes for that variant and mode.

Each write leaves the block as one command on a byte-level I2C master interface. The command carries the device address, the register index and the data byte, with a stop after them. The table can also hold settle gaps, which pause the stream for 10 ms. The gap length comes from the clock frequency parameter, so the same table can be run with a short gap in simulation.

The sequence ends with `done` high or `fail` high, and `variant` reports what was found. A later start strobe runs the whole bring-up again from the first probe.

Top module: `rtcfg_seq`

## Requirements
- R1: After reset, `done`, `fail` and `cmd_valid` are low and `variant` is 0.
- R2: After start, the first command is a read (`cmd_rnw`=1, `cmd_len`=0) to address 0x2C. A read to 0x5E is issued only if 0x2C answered with a nack.
- R3: If both probes are nacked, `fail` rises, `variant` stays 0 (encoding: 0 none, 1 device at 0x2C, 2 device at 0x5E) and no further command is issued.
- R4: With the 0x2C device, mode 2 is used above 3400 Mbps, mode 1 above 1200 Mbps, and mode 0 otherwise.
- R5: With the 0x5E device, mode 2 is used above 3400 Mbps, mode 1 above 2000 Mbps, and mode 0 otherwise. The writes are, in order: reg 0x09←0x06, reg 0x0B, reg 0x0C, reg 0x0D←0x00, reg 0x0A. The 0x0B/0x0C/0x0A data is 0x80/0x48/0x35 in mode 0, 0x88/0x48/0x35 in mode 1, and 0x9A/0x49/0x36 in mode 2.
- R6: Every write is a single command to the detected address with `cmd_rnw`=0, `cmd_len`=2, `cmd_b0` = register index and `cmd_b1` = data. A command is held stable until `cmd_ready`.
- R7: For the 0x2C device, the first write is page reg 0xFF←0x01, and 0xFF←0x00 comes right before the closing hot-plug steps.
- R8: For the 0x2C device, at least 10 ms (CLK_HZ/100 cycles) separate the charge-pump write 0x01←0x81 from the next write, 0x00←0x02. The same gap separates 0x00←0x02 from 0x00←0x03.
- R9: For the 0x2C device, reg 0x13←0x0F is followed immediately by 0x13←0x00.
- R10: For the 0x2C device, the last three writes are 0x09←0x01, 0xE0←0x01 and 0x09←0x00. `done` then rises.
- R11: For the 0x2C device, the mode-specific writes are as follows. 0x04/0x05 is 0x80/0x02 in modes 0 and 2 and 0x40/0x01 in mode 1. 0x08 is 0x02 in mode 0 and 0x04 otherwise. 0x11 is 0xC0/0x70/0x30, 0x31 is 0xC0/0x40/0x00 and 0x4D is 0x38/0x28/0x18 for modes 0/1/2. The full write order is 0xFF, 0x04, 0x05, 0x08, 0x0E←0x10, 0x01←0x81, gap, 0x00←0x02, gap, 0x00←0x03, 0x10←0x0F, 0x14←0x10, 0x16←0x10, 0x17←0x00, 0x12←0x28, 0x13 pulse, 0x11, 0x30←0x0F, 0x32←0x00, 0x31, 0x34←0x00, 0x3C←0x04, 0x3D←0x06, 0x4D, 0x4C←0x03, then the closing steps.
- R12: A nack on any write ends the run: `fail` rises and no further command is issued.
- R13: A start strobe while a run is in progress has no effect. A start strobe after `done` or `fail` restarts from the 0x2C probe.
- R14: `done` and `fail` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle strobe that begins a bring-up |
| line_rate_mbps | input | 16 | Transmit line rate in Mbps |
| cmd_valid | output | 1 | Command offered to the I2C master |
| cmd_ready | input | 1 | Master accepts the command |
| cmd_rnw | output | 1 | 1 = read, 0 = write |
| cmd_addr | output | 7 | 7-bit device address |
| cmd_len | output | 2 | Number of payload bytes (0 or 2) |
| cmd_b0 | output | 8 | First payload byte (register index) |
| cmd_b1 | output | 8 | Second payload byte (data) |
| rsp_valid | input | 1 | One-cycle completion of the accepted command |
| rsp_ack | input | 1 | 1 = all bytes acknowledged |
| done | output | 1 | Bring-up finished |
| fail | output | 1 | Bring-up aborted |
| variant | output | 2 | Detected device: 0 none, 1 at 0x2C, 2 at 0x5E |

## Verification
The assertions take three things for granted about the master:
- it gives exactly one `rsp_valid` pulse for each accepted command;
- that pulse comes at least one cycle after acceptance;
- it never answers while a command is still on offer.

The bench responder keeps to this. It holds `cmd_ready` high, logs each command at acceptance, and returns the ack two cycles later. While a response is pending it accepts nothing new. `line_rate_mbps` is held steady for the whole of a run, so the mode is taken from a settled value.

// File: rtl/rtcfg_pkg.sv
`timescale 1ns/1ps
package rtcfg_pkg;

    localparam logic [6:0] ADDR_LO = 7'h2C;
    localparam logic [6:0] ADDR_HI = 7'h5E;

    localparam logic [1:0] VAR_NONE = 2'd0;
    localparam logic [1:0] VAR_LO   = 2'd1;
    localparam logic [1:0] VAR_HI   = 2'd2;

    localparam int STEP_POS_W = 5;

    typedef enum logic [1:0] {
        STEP_WR   = 2'd0,
        STEP_WAIT = 2'd1,
        STEP_END  = 2'd2
    } step_kind_e;

    typedef struct packed {
        step_kind_e  kind;
        logic [7:0]  idx;
        logic [7:0]  val;
    } step_t;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_PROBE_LO = 3'd1,
        S_PROBE_HI = 3'd2,
        S_FETCH    = 3'd3,
        S_WRITE    = 3'd4,
        S_SETTLE   = 3'd5,
        S_DONE     = 3'd6,
        S_FAIL     = 3'd7
    } seq_state_e;

endpackage

// File: rtl/rtcfg_mode_sel.sv
`timescale 1ns/1ps
module rtcfg_mode_sel
    import rtcfg_pkg::*;
#(
    parameter int RATE_W      = 16,
    parameter int TOP_MBPS    = 3400,
    parameter int LO_MID_MBPS = 1200,
    parameter int HI_MID_MBPS = 2000
) (
    input  logic [1:0]        variant,
    input  logic [RATE_W-1:0] rate_mbps,
    output logic [1:0]        mode
);
    localparam logic [RATE_W-1:0] TOP_L    = RATE_W'(TOP_MBPS);
    localparam logic [RATE_W-1:0] LO_MID_L = RATE_W'(LO_MID_MBPS);
    localparam logic [RATE_W-1:0] HI_MID_L = RATE_W'(HI_MID_MBPS);

    logic [RATE_W-1:0] mid_l;

    always_comb begin
        mid_l = (variant == VAR_HI) ? HI_MID_L : LO_MID_L;
        if (rate_mbps > TOP_L)
            mode = 2'd2;
        else if (rate_mbps > mid_l)
            mode = 2'd1;
        else
            mode = 2'd0;
    end
endmodule

// File: rtl/rtcfg_step_rom.sv
`timescale 1ns/1ps
module rtcfg_step_rom
    import rtcfg_pkg::*;
(
    input  logic [1:0]            variant,
    input  logic [1:0]            mode,
    input  logic [STEP_POS_W-1:0] pos,
    output step_t                 step
);
    function automatic logic [7:0] by_mode(input logic [1:0] m, input logic [7:0] v0,
                                           input logic [7:0] v1, input logic [7:0] v2);
        case (m)
            2'd2:    return v2;
            2'd1:    return v1;
            default: return v0;
        endcase
    endfunction

    function automatic step_t wr(input logic [7:0] r, input logic [7:0] d);
        step_t s;
        s.kind = STEP_WR;
        s.idx  = r;
        s.val  = d;
        return s;
    endfunction

    function automatic step_t gap();
        step_t s;
        s.kind = STEP_WAIT;
        s.idx  = 8'h00;
        s.val  = 8'h00;
        return s;
    endfunction

    function automatic step_t fin();
        step_t s;
        s.kind = STEP_END;
        s.idx  = 8'h00;
        s.val  = 8'h00;
        return s;
    endfunction

    always_comb begin
        step = fin();
        if (variant == VAR_LO) begin
            case (pos)
                5'd0:  step = wr(8'hFF, 8'h01);
                5'd1:  step = wr(8'h04, by_mode(mode, 8'h80, 8'h40, 8'h80));
                5'd2:  step = wr(8'h05, by_mode(mode, 8'h02, 8'h01, 8'h02));
                5'd3:  step = wr(8'h08, by_mode(mode, 8'h02, 8'h04, 8'h04));
                5'd4:  step = wr(8'h0E, 8'h10);
                5'd5:  step = wr(8'h01, 8'h81);
                5'd6:  step = gap();
                5'd7:  step = wr(8'h00, 8'h02);
                5'd8:  step = gap();
                5'd9:  step = wr(8'h00, 8'h03);
                5'd10: step = wr(8'h10, 8'h0F);
                5'd11: step = wr(8'h14, 8'h10);
                5'd12: step = wr(8'h16, 8'h10);
                5'd13: step = wr(8'h17, 8'h00);
                5'd14: step = wr(8'h12, 8'h28);
                5'd15: step = wr(8'h13, 8'h0F);
                5'd16: step = wr(8'h13, 8'h00);
                5'd17: step = wr(8'h11, by_mode(mode, 8'hC0, 8'h70, 8'h30));
                5'd18: step = wr(8'h30, 8'h0F);
                5'd19: step = wr(8'h32, 8'h00);
                5'd20: step = wr(8'h31, by_mode(mode, 8'hC0, 8'h40, 8'h00));
                5'd21: step = wr(8'h34, 8'h00);
                5'd22: step = wr(8'h3C, 8'h04);
                5'd23: step = wr(8'h3D, 8'h06);
                5'd24: step = wr(8'h4D, by_mode(mode, 8'h38, 8'h28, 8'h18));
                5'd25: step = wr(8'h4C, 8'h03);
                5'd26: step = wr(8'hFF, 8'h00);
                5'd27: step = wr(8'h09, 8'h01);
                5'd28: step = wr(8'hE0, 8'h01);
                5'd29: step = wr(8'h09, 8'h00);
                default: step = fin();
            endcase
        end else if (variant == VAR_HI) begin
            case (pos)
                5'd0: step = wr(8'h09, 8'h06);
                5'd1: step = wr(8'h0B, by_mode(mode, 8'h80, 8'h88, 8'h9A));
                5'd2: step = wr(8'h0C, by_mode(mode, 8'h48, 8'h48, 8'h49));
                5'd3: step = wr(8'h0D, 8'h00);
                5'd4: step = wr(8'h0A, by_mode(mode, 8'h35, 8'h35, 8'h36));
                default: step = fin();
            endcase
        end
    end
endmodule

// File: rtl/rtcfg_seq.sv
`timescale 1ns/1ps
module rtcfg_seq
    import rtcfg_pkg::*;
#(
    parameter int CLK_HZ     = 200_000_000,
    parameter int SETTLE_DIV = 100,
    parameter int RATE_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RATE_W-1:0] line_rate_mbps,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_rnw,
    output logic [6:0]        cmd_addr,
    output logic [1:0]        cmd_len,
    output logic [7:0]        cmd_b0,
    output logic [7:0]        cmd_b1,
    input  logic              rsp_valid,
    input  logic              rsp_ack,
    output logic              done,
    output logic              fail,
    output logic [1:0]        variant
);
    localparam int SETTLE_RAW = CLK_HZ / SETTLE_DIV;
    localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
    localparam int CNT_W      = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        seq_state_e            st;
        logic [STEP_POS_W-1:0] pos;
        logic [1:0]            variant;
        logic [1:0]            mode;
        logic [CNT_W-1:0]      cnt;
        logic                  cv;
        logic                  rnw;
        logic [6:0]            addr;
        logic [1:0]            len;
        logic [7:0]            b0;
        logic [7:0]            b1;
        logic                  done;
        logic                  fail;
    } regs_t;

    regs_t      r_q, r_d;
    logic [1:0] probe_var;
    logic [1:0] probe_mode;
    step_t      step;
    logic       start_ok;

    assign probe_var = (r_q.st == S_PROBE_HI) ? VAR_HI : VAR_LO;

    rtcfg_mode_sel #(.RATE_W(RATE_W)) u_mode (
        .variant   (probe_var),
        .rate_mbps (line_rate_mbps),
        .mode      (probe_mode)
    );

    rtcfg_step_rom u_rom (
        .variant (r_q.variant),
        .mode    (r_q.mode),
        .pos     (r_q.pos),
        .step    (step)
    );

    always_comb begin
        r_d      = r_q;
        start_ok = start && ((r_q.st == S_IDLE) || (r_q.st == S_DONE) || (r_q.st == S_FAIL));
        case (r_q.st)
            S_PROBE_LO, S_PROBE_HI: begin
                if (r_q.cv) begin
                    if (cmd_ready) r_d.cv = 1'b0;
                end else if (rsp_valid) begin
                    if (rsp_ack) begin
                        r_d.variant = probe_var;
                        r_d.mode    = probe_mode;
                        r_d.pos     = '0;
                        r_d.st      = S_FETCH;
                    end else if (r_q.st == S_PROBE_LO) begin
                        r_d.cv   = 1'b1;
                        r_d.addr = ADDR_HI;
                        r_d.st   = S_PROBE_HI;
                    end else begin
                        r_d.fail = 1'b1;
                        r_d.st   = S_FAIL;
                    end
                end
            end
            S_FETCH: begin
                case (step.kind)
                    STEP_WR: begin
                        r_d.cv   = 1'b1;
                        r_d.rnw  = 1'b0;
                        r_d.len  = 2'd2;
                        r_d.addr = (r_q.variant == VAR_LO) ? ADDR_LO : ADDR_HI;
                        r_d.b0   = step.idx;
                        r_d.b1   = step.val;
                        r_d.st   = S_WRITE;
                    end
                    STEP_WAIT: begin
                        r_d.cnt = CNT_W'(SETTLE_CYC - 1);
                        r_d.st  = S_SETTLE;
                    end
                    default: begin
                        r_d.done = 1'b1;
                        r_d.st   = S_DONE;
                    end
                endcase
            end
            S_WRITE: begin
                if (r_q.cv) begin
                    if (cmd_ready) r_d.cv = 1'b0;
                end else if (rsp_valid) begin
                    if (rsp_ack) begin
                        r_d.pos = r_q.pos + 1'b1;
                        r_d.st  = S_FETCH;
                    end else begin
                        r_d.fail = 1'b1;
                        r_d.st   = S_FAIL;
                    end
                end
            end
            S_SETTLE: begin
                if (r_q.cnt == '0) begin
                    r_d.pos = r_q.pos + 1'b1;
                    r_d.st  = S_FETCH;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: begin
                if (start_ok) begin
                    r_d.done    = 1'b0;
                    r_d.fail    = 1'b0;
                    r_d.variant = VAR_NONE;
                    r_d.cv      = 1'b1;
                    r_d.rnw     = 1'b1;
                    r_d.addr    = ADDR_LO;
                    r_d.len     = 2'd0;
                    r_d.b0      = 8'h00;
                    r_d.b1      = 8'h00;
                    r_d.st      = S_PROBE_LO;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st      <= S_IDLE;
            r_q.pos     <= '0;
            r_q.variant <= VAR_NONE;
            r_q.mode    <= 2'd0;
            r_q.cnt     <= '0;
            r_q.cv      <= 1'b0;
            r_q.rnw     <= 1'b0;
            r_q.addr    <= 7'h00;
            r_q.len     <= 2'd0;
            r_q.b0      <= 8'h00;
            r_q.b1      <= 8'h00;
            r_q.done    <= 1'b0;
            r_q.fail    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_valid = r_q.cv;
    assign cmd_rnw   = r_q.rnw;
    assign cmd_addr  = r_q.addr;
    assign cmd_len   = r_q.len;
    assign cmd_b0    = r_q.b0;
    assign cmd_b1    = r_q.b1;
    assign done      = r_q.done;
    assign fail      = r_q.fail;
    assign variant   = r_q.variant;
endmodule

// File: rtl/rtcfg_seq_chk.sv
`timescale 1ns/1ps
module rtcfg_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic       cmd_rnw,
    input logic [6:0] cmd_addr,
    input logic [1:0] cmd_len,
    input logic [7:0] cmd_b0,
    input logic [7:0] cmd_b1,
    input logic       rsp_valid,
    input logic       done,
    input logic       fail,
    input logic [1:0] variant
);
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable({cmd_rnw, cmd_addr, cmd_len, cmd_b0, cmd_b1})); // R6

    AST_READ_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_rnw |-> cmd_len == 2'd0 && (cmd_addr == 7'h2C || cmd_addr == 7'h5E)); // R2

    AST_WRITE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_rnw |-> cmd_len == 2'd2 &&
        ((variant == 2'd1 && cmd_addr == 7'h2C) || (variant == 2'd2 && cmd_addr == 7'h5E))); // R6

    AST_RSP_NOT_WHILE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_valid); // R6

    AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail)); // R14

    AST_QUIET_WHEN_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |-> !cmd_valid); // R12

    AST_DONE_HAS_VARIANT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> variant != 2'd0); // R3
endmodule

bind rtcfg_seq rtcfg_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_rnw   (cmd_rnw),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .cmd_b0    (cmd_b0),
    .cmd_b1    (cmd_b1),
    .rsp_valid (rsp_valid),
    .done      (done),
    .fail      (fail),
    .variant   (variant)
);

// File: tb/tb_rtcfg_seq.sv
`timescale 1ns/1ps
module tb_rtcfg_seq;
    localparam int CLK_HZ = 2000;
    localparam int SETTLE = CLK_HZ / 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [15:0] rate = 16'd0;
    logic       cmd_valid, cmd_rnw;
    logic       cmd_ready = 1'b1;
    logic [6:0] cmd_addr;
    logic [1:0] cmd_len;
    logic [7:0] cmd_b0, cmd_b1;
    logic       rsp_valid = 1'b0, rsp_ack = 1'b0;
    logic       done, fail;
    logic [1:0] variant;

    rtcfg_seq #(.CLK_HZ(CLK_HZ)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .line_rate_mbps(rate),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_rnw(cmd_rnw),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_b0(cmd_b0), .cmd_b1(cmd_b1),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
        .done(done), .fail(fail), .variant(variant)
    );

    initial forever #2.5 clk = ~clk;

    int nvec = 0, nfail = 0, cyc = 0;
    initial forever begin @(posedge clk); cyc++; end

    // command log filled by the responder
    logic [6:0] lg_addr [0:63];
    logic       lg_rnw  [0:63];
    logic [1:0] lg_len  [0:63];
    logic [7:0] lg_b0   [0:63];
    logic [7:0] lg_b1   [0:63];
    int         lg_cyc  [0:63];
    int         n_log = 0;
    bit         dev_lo = 1'b0, dev_hi = 1'b0;
    int         nack_at = -1;

    initial begin
        int  pend;
        bit  pend_ack;
        pend = 0;
        pend_ack = 1'b0;
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            rsp_ack   = 1'b0;
            if (!rst_n) begin
                pend = 0;
            end else if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    rsp_valid = 1'b1;
                    rsp_ack   = pend_ack;
                end
            end else if (cmd_valid && cmd_ready) begin
                if (cmd_rnw)
                    pend_ack = (cmd_addr == 7'h2C) ? dev_lo : (cmd_addr == 7'h5E) ? dev_hi : 1'b0;
                else
                    pend_ack = (n_log != nack_at);
                if (n_log < 64) begin
                    lg_addr[n_log] = cmd_addr; lg_rnw[n_log] = cmd_rnw; lg_len[n_log] = cmd_len;
                    lg_b0[n_log] = cmd_b0; lg_b1[n_log] = cmd_b1; lg_cyc[n_log] = cyc;
                end
                n_log++;
                pend = 2;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected write list, written from the requirements
    logic [7:0] ex_r [0:31];
    logic [7:0] ex_d [0:31];
    int         n_ex;

    task automatic push(input logic [7:0] r, input logic [7:0] d);
        ex_r[n_ex] = r; ex_d[n_ex] = d; n_ex++;
    endtask

    function automatic logic [7:0] pick(input int m, input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        return (m == 2) ? c : (m == 1) ? b : a;
    endfunction

    task automatic build_exp(input int v, input int m);
        n_ex = 0;
        if (v == 1) begin
            push(8'hFF, 8'h01);
            push(8'h04, pick(m, 8'h80, 8'h40, 8'h80));
            push(8'h05, pick(m, 8'h02, 8'h01, 8'h02));
            push(8'h08, pick(m, 8'h02, 8'h04, 8'h04));
            push(8'h0E, 8'h10); push(8'h01, 8'h81);
            push(8'h00, 8'h02); push(8'h00, 8'h03);
            push(8'h10, 8'h0F); push(8'h14, 8'h10); push(8'h16, 8'h10);
            push(8'h17, 8'h00); push(8'h12, 8'h28);
            push(8'h13, 8'h0F); push(8'h13, 8'h00);
            push(8'h11, pick(m, 8'hC0, 8'h70, 8'h30));
            push(8'h30, 8'h0F); push(8'h32, 8'h00);
            push(8'h31, pick(m, 8'hC0, 8'h40, 8'h00));
            push(8'h34, 8'h00); push(8'h3C, 8'h04); push(8'h3D, 8'h06);
            push(8'h4D, pick(m, 8'h38, 8'h28, 8'h18));
            push(8'h4C, 8'h03); push(8'hFF, 8'h00);
            push(8'h09, 8'h01); push(8'hE0, 8'h01); push(8'h09, 8'h00);
        end else if (v == 2) begin
            push(8'h09, 8'h06);
            push(8'h0B, pick(m, 8'h80, 8'h88, 8'h9A));
            push(8'h0C, pick(m, 8'h48, 8'h48, 8'h49));
            push(8'h0D, 8'h00);
            push(8'h0A, pick(m, 8'h35, 8'h35, 8'h36));
        end
    endtask

    task automatic run_one(input logic [15:0] r, input bit lo, input bit hi, input int nk, input bit mid);
        bit pulsed;
        int t;
        pulsed = 1'b0;
        @(negedge clk);
        rate = r; dev_lo = lo; dev_hi = hi; nack_at = nk; n_log = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (t = 0; t < 4000 && !(done || fail); t++) begin
            @(negedge clk);
            start = 1'b0;
            if (mid && !pulsed && n_log == 4) begin
                start = 1'b1;
                pulsed = 1'b1;
            end
        end
        start = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    // compare logged writes from position base against the expected list
    task automatic cmp_writes(input int base, input logic [6:0] a, input string req);
        int bad;
        bad = -1;
        for (int i = 0; i < n_ex; i++) begin
            if (bad < 0 && (lg_addr[base+i] != a || lg_rnw[base+i] != 1'b0 || lg_len[base+i] != 2'd2 ||
                            lg_b0[base+i] != ex_r[i] || lg_b1[base+i] != ex_d[i]))
                bad = i;
        end
        if (bad < 0)
            chk(1'b1, req, "write stream", 0, 0);
        else
            chk(1'b0, req, $sformatf("write %0d reg/data", bad),
                {lg_b0[base+bad], lg_b1[base+bad]}, {ex_r[bad], ex_d[bad]});
    endtask

    typedef struct packed {
        logic [15:0] rate;
        logic        lo;
        logic        hi;
        logic [1:0]  var_e;
        logic [1:0]  mode_e;
    } vec_t;

    localparam vec_t VEC [0:10] = '{
        '{16'd5000, 1'b1, 1'b1, 2'd1, 2'd2},
        '{16'd3401, 1'b1, 1'b0, 2'd1, 2'd2},
        '{16'd3400, 1'b1, 1'b0, 2'd1, 2'd1},
        '{16'd1201, 1'b1, 1'b0, 2'd1, 2'd1},
        '{16'd1200, 1'b1, 1'b0, 2'd1, 2'd0},
        '{16'd250,  1'b1, 1'b0, 2'd1, 2'd0},
        '{16'd4752, 1'b0, 1'b1, 2'd2, 2'd2},
        '{16'd3400, 1'b0, 1'b1, 2'd2, 2'd1},
        '{16'd2001, 1'b0, 1'b1, 2'd2, 2'd1},
        '{16'd2000, 1'b0, 1'b1, 2'd2, 2'd0},
        '{16'd1500, 1'b0, 1'b0, 2'd0, 2'd0}
    };

    bit finished = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nvec++; nfail++;
            $display("FAIL watchdog R14: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        int base, k;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(done == 1'b0 && fail == 1'b0, "R1", "done/fail at reset", {done, fail}, 0);
        chk(variant == 2'd0, "R1", "variant at reset", variant, 0);
        chk(cmd_valid == 1'b0, "R1", "cmd_valid at reset", cmd_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;

        foreach (VEC[v]) begin
            run_one(VEC[v].rate, VEC[v].lo, VEC[v].hi, -1, 1'b0);
            chk(n_log > 0 && lg_addr[0] == 7'h2C && lg_rnw[0] == 1'b1 && lg_len[0] == 2'd0,
                "R2", "first probe", lg_addr[0], 7'h2C);
            if (VEC[v].lo)
                chk(n_log < 2 || lg_rnw[1] == 1'b0, "R2", "no second probe", lg_rnw[1], 0);
            else
                chk(n_log > 1 && lg_addr[1] == 7'h5E && lg_rnw[1] == 1'b1, "R2", "second probe", lg_addr[1], 7'h5E);
            if (VEC[v].var_e == 2'd0) begin
                chk(fail == 1'b1 && done == 1'b0 && variant == 2'd0, "R3", "no device outcome",
                    {fail, done, variant}, 4'b1000);
                chk(n_log == 2, "R3", "commands after probes", n_log, 2);
            end else begin
                base = VEC[v].lo ? 1 : 2;
                build_exp(VEC[v].var_e, VEC[v].mode_e);
                chk(n_log == base + n_ex, (VEC[v].var_e == 2'd1) ? "R4" : "R5", "command count",
                    n_log, base + n_ex);
                cmp_writes(base, (VEC[v].var_e == 2'd1) ? 7'h2C : 7'h5E,
                           (VEC[v].var_e == 2'd1) ? "R4/R11/R6" : "R5/R6");
                chk(done == 1'b1 && fail == 1'b0, "R14", "done only", {done, fail}, 2'b10);
                chk(variant == VEC[v].var_e, "R4/R5", "variant", variant, VEC[v].var_e);
            end
        end

        // R13 restart after fail (last vector failed)
        run_one(16'd4752, 1'b1, 1'b0, -1, 1'b0);
        chk(lg_addr[0] == 7'h2C && done == 1'b1 && fail == 1'b0, "R13", "restart after fail",
            {lg_addr[0], done}, {7'h2C, 1'b1});

        // R7/R8/R9/R10 on the last 0x2C run, mode 2
        chk(lg_b0[1] == 8'hFF && lg_b1[1] == 8'h01, "R7", "page 1 first", {lg_b0[1], lg_b1[1]}, 16'hFF01);
        chk(lg_b0[n_log-4] == 8'hFF && lg_b1[n_log-4] == 8'h00, "R7", "page 0 before hot-plug",
            {lg_b0[n_log-4], lg_b1[n_log-4]}, 16'hFF00);
        chk(lg_b0[n_log-3] == 8'h09 && lg_b1[n_log-3] == 8'h01 && lg_b0[n_log-2] == 8'hE0 &&
            lg_b1[n_log-2] == 8'h01 && lg_b0[n_log-1] == 8'h09 && lg_b1[n_log-1] == 8'h00,
            "R10", "closing triple", {lg_b0[n_log-1], lg_b1[n_log-1]}, 16'h0900);
        k = -1;
        for (int i = 1; i < n_log - 1; i++)
            if (k < 0 && lg_b0[i] == 8'h13 && lg_b1[i] == 8'h0F) k = i;
        chk(k > 0 && lg_b0[k+1] == 8'h13 && lg_b1[k+1] == 8'h00, "R9", "coefficient pulse",
            {lg_b0[k+1], lg_b1[k+1]}, 16'h1300);
        k = -1;
        for (int i = 1; i < n_log - 2; i++)
            if (k < 0 && lg_b0[i] == 8'h01 && lg_b1[i] == 8'h81) k = i;
        chk(k > 0 && lg_cyc[k+1] - lg_cyc[k] >= SETTLE + 4 && lg_cyc[k+1] - lg_cyc[k] <= SETTLE + 6,
            "R8", "gap after charge pump", lg_cyc[k+1] - lg_cyc[k], SETTLE + 5);
        chk(k > 0 && lg_cyc[k+2] - lg_cyc[k+1] >= SETTLE + 4 && lg_cyc[k+2] - lg_cyc[k+1] <= SETTLE + 6,
            "R8", "gap after bandgap", lg_cyc[k+2] - lg_cyc[k+1], SETTLE + 5);
        chk(k > 0 && lg_cyc[k] - lg_cyc[k-1] < SETTLE, "R8", "no gap elsewhere",
            lg_cyc[k] - lg_cyc[k-1], 4);

        // R12 nack on the fifth write (log index 5)
        run_one(16'd1000, 1'b1, 1'b0, 5, 1'b0);
        chk(fail == 1'b1 && done == 1'b0, "R12", "abort on nack", {fail, done}, 2'b10);
        chk(n_log == 6, "R12", "no command after nack", n_log, 6);

        // R13 start while busy is ignored
        run_one(16'd2500, 1'b0, 1'b1, -1, 1'b1);
        build_exp(2, 1);
        chk(n_log == 2 + n_ex && done == 1'b1, "R13", "start while busy ignored", n_log, 2 + n_ex);
        cmp_writes(2, 7'h5E, "R13");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule